// File: doc/BRIEF.md
# Dual-Mode Prescaled Tick Counter

This block is a free-running 8-bit up-counter for timing, read by software. A 4-bit prescaler divides the system clock by sixteen and gives a one-cycle enable. On each enable the count goes up by one. A mode input sets the wrap point. Mode 0 counts through the full 8-bit range. Mode 1 counts from 0x00 to 0x66 and then returns to zero, which is modulo 103.

Each pulse on the mode-write strobe clears both the count and the prescaler. This happens even if the new mode equals the old one. Software can therefore restart a timing window by rewriting the mode bit. The count is always driven on an 8-bit output for a register read path.

Top module: `tick_counter`

## Requirements
- R1: While reset is asserted and directly after it is released, `count_o` is 0x00 and the prescaler phase is zero.
- R2: The count rises by exactly one for every 16 clock cycles. The first increment after reset appears after the 16th rising edge.
- R3: With `mode_i` = 0, the count runs from 0x00 to 0xFF and wraps to 0x00 on the next increment.
- R4: With `mode_i` = 1, the count runs from 0x00 to 0x66 and wraps to 0x00 on the next increment. It never shows a value above 0x66.
- R5: On a clock edge where `mode_wr_i` is 1, the count becomes 0x00 and the prescaler restarts. The next increment comes 16 cycles after that edge.
- R6: A mode write that keeps the same `mode_i` value still clears the count and the prescaler.
- R7: If a mode write and a prescaler enable fall on the same edge, the clear wins and the count is 0x00.
- R8: A write that switches to mode 1 while the count is above 0x66 leaves the count at 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Wrap mode: 0 = modulo 256, 1 = modulo 103 |
| mode_wr_i | input | 1 | One-cycle strobe for a mode-register write |
| count_o | output | 8 | Current count value |

## Verification
The assertions assume that `mode_i` changes only in a cycle where `mode_wr_i` is high. The range check for mode 1 relies on this, because a mode change without a write would leave an out-of-range count in place. The bench follows this rule: it sets `mode_i` only in the same cycle as the write strobe. It computes the expected count as the number of edges since the last clear, divided by 16, modulo 256 or 103. It times one write to land on the prescaler's final phase and another on a mid phase.

// File: rtl/tick_counter_pkg.sv
package tick_counter_pkg;
  typedef enum logic {
    WRAP_FULL = 1'b0,
    WRAP_ALT  = 1'b1
  } wrap_mode_e;

  localparam int unsigned DEF_CNT_W     = 8;
  localparam int unsigned DEF_PRE_W     = 4;
  localparam int unsigned DEF_ALT_COUNT = 103;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  logic [PRE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end

  // enable on the last phase so the first step lands 2**PRE_W edges after clear
  assign tick_o = &phase_q;
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter
  import tick_counter_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ALT_COUNT = 103
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  wrap_mode_e       mode_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ALT_LAST  = CNT_W'(ALT_COUNT - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic             at_last;

  generate
    if (ALT_COUNT >= (1 << CNT_W)) begin : g_no_alt
      assign last = FULL_LAST;
    end else begin : g_alt
      assign last = (mode_i == WRAP_ALT) ? ALT_LAST : FULL_LAST;
    end
  endgenerate

  assign at_last = (cnt_q >= last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;   // clear beats tick
    else if (tick_i) cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_counter_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned PRE_W     = DEF_PRE_W,
  parameter int unsigned ALT_COUNT = DEF_ALT_COUNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             mode_wr_i,
  output logic [CNT_W-1:0] count_o
);
  logic       tick;
  wrap_mode_e mode;

  assign mode = wrap_mode_e'(mode_i);

  tick_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mode_wr_i),
    .tick_o (tick)
  );

  wrap_counter #(.CNT_W(CNT_W), .ALT_COUNT(ALT_COUNT)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_wr_i),
    .tick_i  (tick),
    .mode_i  (mode),
    .count_o (count_o)
  );
endmodule

// File: rtl/tick_counter_chk.sv
module tick_counter_chk #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ALT_COUNT = 103
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             mode_wr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             tick_i
);
  localparam logic [CNT_W-1:0] ALT_LAST = CNT_W'(ALT_COUNT - 1);

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |=> count_o == '0);

  // R5
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> count_o == '0);

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !mode_wr_i) |=> $stable(count_o));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !mode_wr_i) |=> (count_o == $past(count_o) + 1'b1) || (count_o == '0));

  // R2
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  // R4
  alt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !mode_wr_i) |-> count_o <= ALT_LAST);

  // R7
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_wr_i) |=> count_o == '0);
endmodule

bind tick_counter tick_counter_chk #(.CNT_W(CNT_W), .ALT_COUNT(ALT_COUNT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .mode_wr_i (mode_wr_i),
  .count_o   (count_o),
  .tick_i    (tick)
);

// File: tb/sim_tick_counter.sv
`timescale 1ns/1ps
module sim_tick_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic       mode_wr_i = 1'b0;
  logic [7:0] count_o;

  int n_run = 0;
  int n_fail = 0;
  int edges = 0;   // edges since last clear
  bit cur_mode = 1'b0;
  bit done = 1'b0;

  tick_counter u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .mode_wr_i (mode_wr_i),
    .count_o   (count_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic int expect_cnt();
    int m = cur_mode ? 103 : 256;
    return (edges / 16) % m;
  endfunction

  task automatic check(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: count=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock; wr applies to this edge, sampled 2 ns after it
  task automatic cyc(input bit wr, input bit m, input string req);
    mode_wr_i = wr;
    if (wr) mode_i = m;
    @(posedge clk_i);
    #2;
    if (wr) begin
      edges = 0;
      cur_mode = m;
    end else begin
      edges++;
    end
    mode_wr_i = 1'b0;
    check(int'(count_o), expect_cnt(), req);
  endtask

  initial begin
    #2;
    check(int'(count_o), 0, "R1");
    @(posedge clk_i);
    #2;
    check(int'(count_o), 0, "R1");
    rst_ni = 1'b1;
    edges = 0;
    // R2: step every 16 edges, first increment after 16th
    for (int i = 0; i < 16 * 200 + 3; i++) cyc(1'b0, 1'b0, "R2");
    // R8: switch to mode 1 while count is 0xC8
    cyc(1'b1, 1'b1, "R8");
    // R5: stays zero for 15 edges, 1 after the 16th
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, "R5");
    // R4: two full alternate wraps
    for (int i = 0; i < 103 * 16 * 2 + 20; i++) cyc(1'b0, 1'b1, "R4");
    // R6: same-mode rewrite mid-phase
    while (edges % 16 != 7) cyc(1'b0, 1'b1, "R4");
    cyc(1'b1, 1'b1, "R6");
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, "R6");
    // R7: write lands on the prescaler's last phase
    while (edges % 16 != 15) cyc(1'b0, 1'b1, "R4");
    cyc(1'b1, 1'b0, "R7");
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, "R7");
    // R3: full wrap in mode 0
    for (int i = 0; i < 256 * 16 + 50; i++) cyc(1'b0, 1'b0, "R3");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: count=%0h expected=done", count_o);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule